// File: doc/BRIEF.md
# UART Interrupt Source Generator

This block produces the separate interrupt conditions of a serial port receiver/controller and merges them into one request line. It watches three modem handshake inputs, the port enable, the raw serial receive line, the receive FIFO fill level and its push/pop events, and a one-cycle tick that marks each bit period.

There are three sources. The modem-status source latches any level change on the handshake lines and holds until software clears it. The disabled source reports a start bit (low) seen on the receive line while the port is switched off, and it drops by itself. The receive source flags either a half-full FIFO in FIFO mode or a receive idle timeout. The combined request is the OR of the three sources after a per-source enable.

Asynchronous inputs (modem lines and the receive line) pass through two-flop synchronisers. The FIFO level, push, pop, tick, enable and clear inputs are taken as synchronous to `clk`.

Top module: `uart_irq_gen`

## Requirements
- R1: A level change on any `modem_in` bit (bit 2 carrier detect, bit 1 data-set-ready, bit 0 clear-to-send) sets `irq_modem` on the third rising clock edge after the change.
- R2: `irq_modem` stays set until a rising edge with `modem_clr` high. If a new modem change is detected on that same edge, `irq_modem` stays set.
- R3: After reset, all four outputs are low. The receive line synchroniser starts at the idle (high) level.
- R4: `irq_disabled` is high when `uart_en` is low and the synchronised receive line is low. The receive line is seen two rising edges after it changes.
- R5: `irq_disabled` drops within the same cycle when `uart_en` goes high. It drops two edges after the receive line returns high.
- R6: With `fifo_mode` high, `irq_rx` is high whenever `rx_level` is 8 or more (half of the 16-entry depth).
- R7: With `fifo_mode` low, the fill-level threshold has no effect on `irq_rx`.
- R8: The idle timeout sets `irq_rx` on the edge that takes the 33rd `bit_tick` counted with no push or pop and a non-empty FIFO. After only 32 ticks it stays low.
- R9: Once set, the timeout holds until an edge with `rx_push`, `rx_pop` or `rx_level` equal to 0. That edge clears it and restarts the count.
- R10: `irq_any` is the OR of each source ANDed with its enable in `irq_en`, where bit 0 is modem, bit 1 is disabled and bit 2 is receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| modem_in | input | 3 | Asynchronous modem lines {dcd, dsr, cts} |
| uart_en | input | 1 | Port enable |
| rx_line | input | 1 | Asynchronous serial receive line |
| fifo_mode | input | 1 | FIFO mode on (threshold active) |
| rx_level | input | 5 | Receive FIFO fill level, 0 to 16 |
| rx_push | input | 1 | A character is written into the receive FIFO |
| rx_pop | input | 1 | The host reads a character |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| modem_clr | input | 1 | Write-to-clear of the modem-status source |
| irq_en | input | 3 | Per-source enable for `irq_any` |
| irq_modem | output | 1 | Modem-status interrupt |
| irq_disabled | output | 1 | Start-bit-while-disabled interrupt |
| irq_rx | output | 1 | Receive threshold or timeout interrupt |
| irq_any | output | 1 | Combined enabled interrupt |

## Verification
Suppose the modem change detector holds a stale previous value. Then `irq_modem` would rise when the line has not changed, or stay low when it has, and the error shows up three edges after the change. If the timeout counter drifts, is not restarted, or saturates at the wrong count, `irq_rx` goes wrong one tick early or late at the 32/33 boundary. It also stays wrong for as long as the FIFO stays idle. A fault in the synchroniser reset value or in its depth shows on `irq_disabled` right after reset, or one edge away from the expected two-edge latency.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC   = 3;
    localparam int SRC_MODEM = 0;
    localparam int SRC_DIS   = 1;
    localparam int SRC_RX    = 2;

    typedef struct packed {
        logic dcd;
        logic dsr;
        logic cts;
    } modem_t;

    typedef struct packed {
        logic rx;
        logic dis;
        logic modem;
    } irq_vec_t;

    function automatic logic gated_or(input irq_vec_t src, input logic [NUM_SRC-1:0] en);
        return |(src & en);
    endfunction

endpackage

// File: rtl/uart_irq_sync.sv
module uart_irq_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/uart_irq_modem.sv
module uart_irq_modem
    import uart_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  modem_t lines_in,
    input  logic   clr,
    output logic   irq
);
    localparam int MW = $bits(modem_t);

    modem_t lines_s;
    modem_t lines_prev;
    logic   chg;

    uart_irq_sync #(.W(MW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (lines_in),
        .q   (lines_s)
    );

    always_ff @(posedge clk) begin
        if (rst) lines_prev <= '0;
        else     lines_prev <= lines_s;
    end

    assign chg = (lines_s != lines_prev);

    always_ff @(posedge clk) begin
        if (rst)      irq <= 1'b0;
        else if (chg) irq <= 1'b1;
        else if (clr) irq <= 1'b0;
    end

    AST_MODEM_SET: assert property (@(posedge clk) disable iff (rst)
        chg |=> irq); // R1
    AST_MODEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq); // R2
    AST_MODEM_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && !chg) |=> !irq); // R2
endmodule

// File: rtl/uart_irq_rxto.sv
module uart_irq_rxto #(
    parameter int DEPTH = 16,
    parameter int LIMIT = 32,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_mode,
    input  logic [LW-1:0] level,
    input  logic          push,
    input  logic          pop,
    input  logic          tick,
    output logic          irq
);
    localparam int            CW   = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] SAT  = CW'(LIMIT + 1);
    localparam logic [LW-1:0] HALF = LW'(DEPTH / 2);

    logic [CW-1:0] cnt;
    logic          restart;
    logic          timeout;
    logic          thresh;

    assign restart = push || pop || (level == '0);

    always_ff @(posedge clk) begin
        if (rst || restart)          cnt <= '0;
        else if (tick && cnt != SAT) cnt <= cnt + 1'b1;
    end

    assign timeout = (cnt == SAT);
    assign thresh  = fifo_mode && (level >= HALF);
    assign irq     = thresh || timeout;

    AST_TO_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> !timeout); // R9
    AST_TO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (timeout && !restart) |=> timeout); // R9
    AST_TO_STEP: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(cnt)); // R8
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
    import uart_irq_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int LIMIT       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int LW          = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         modem_in,
    input  logic               uart_en,
    input  logic               rx_line,
    input  logic               fifo_mode,
    input  logic [LW-1:0]      rx_level,
    input  logic               rx_push,
    input  logic               rx_pop,
    input  logic               bit_tick,
    input  logic               modem_clr,
    input  logic [NUM_SRC-1:0] irq_en,
    output logic               irq_modem,
    output logic               irq_disabled,
    output logic               irq_rx,
    output logic               irq_any
);
    irq_vec_t src;
    logic     rx_s;

    uart_irq_modem #(.SYNC_STAGES(SYNC_STAGES)) u_modem (
        .clk      (clk),
        .rst      (rst),
        .lines_in (modem_t'(modem_in)),
        .clr      (modem_clr),
        .irq      (src.modem)
    );

    uart_irq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxsync (
        .clk (clk),
        .rst (rst),
        .d   (rx_line),
        .q   (rx_s)
    );

    assign src.dis = !uart_en && !rx_s;

    uart_irq_rxto #(.DEPTH(DEPTH), .LIMIT(LIMIT), .LW(LW)) u_rxto (
        .clk       (clk),
        .rst       (rst),
        .fifo_mode (fifo_mode),
        .level     (rx_level),
        .push      (rx_push),
        .pop       (rx_pop),
        .tick      (bit_tick),
        .irq       (src.rx)
    );

    assign irq_modem    = src.modem;
    assign irq_disabled = src.dis;
    assign irq_rx       = src.rx;
    assign irq_any      = gated_or(src, irq_en);

    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> (!irq_modem && !irq_rx)); // R3
endmodule

// File: tb/uart_irq_gen_bench.sv
module uart_irq_gen_bench;
    localparam int DEPTH = 16;
    localparam int LIMIT = 32;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] modem_in;
    logic       uart_en, rx_line, fifo_mode;
    logic [4:0] rx_level;
    logic       rx_push, rx_pop, bit_tick, modem_clr;
    logic [2:0] irq_en;
    logic       irq_modem, irq_disabled, irq_rx, irq_any;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    uart_irq_gen u_uart_irq_gen (
        .clk(clk), .rst(rst), .modem_in(modem_in), .uart_en(uart_en),
        .rx_line(rx_line), .fifo_mode(fifo_mode), .rx_level(rx_level),
        .rx_push(rx_push), .rx_pop(rx_pop), .bit_tick(bit_tick),
        .modem_clr(modem_clr), .irq_en(irq_en),
        .irq_modem(irq_modem), .irq_disabled(irq_disabled),
        .irq_rx(irq_rx), .irq_any(irq_any)
    );

    // requirement-level reference state
    bit [2:0] m1, m2, mp;
    bit       im;
    bit       r1, r2;
    int       idle;

    always @(posedge clk) begin
        if (rst) begin
            m1 = 0; m2 = 0; mp = 0; im = 0; r1 = 1; r2 = 1; idle = 0;
        end else begin
            if (m2 != mp) im = 1;
            else if (modem_clr) im = 0;
            mp = m2; m2 = m1; m1 = modem_in;
            r2 = r1; r1 = rx_line;
            if (rx_push || rx_pop || rx_level == 0) idle = 0;
            else if (bit_tick && idle <= LIMIT) idle++;
        end
    end

    function automatic bit exp_dis();
        return !uart_en && !r2;
    endfunction
    function automatic bit exp_rx();
        return (fifo_mode && rx_level >= DEPTH/2) || (idle > LIMIT);
    endfunction
    function automatic bit exp_any();
        return (im && irq_en[0]) || (exp_dis() && irq_en[1]) || (exp_rx() && irq_en[2]);
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk("R1 R2 modem vs model", irq_modem, im);
        chk("R4 disabled vs model", irq_disabled, exp_dis());
        chk("R6 R8 rx vs model", irq_rx, exp_rx());
        chk("R10 any vs model", irq_any, exp_any());
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4321));
        rst = 1; modem_in = 0; uart_en = 1; rx_line = 1; fifo_mode = 1;
        rx_level = 0; rx_push = 0; rx_pop = 0; bit_tick = 0; modem_clr = 0;
        irq_en = 3'b111;
        step(); step();
        chk("R3 reset modem", irq_modem, 1'b0);
        chk("R3 reset disabled", irq_disabled, 1'b0);
        chk("R3 reset rx", irq_rx, 1'b0);
        chk("R3 reset any", irq_any, 1'b0);
        rst = 0;
        step();

        // R1 latency, R2 hold and clear
        modem_in[1] = 1;
        step(); step();
        chk("R1 not yet after 2 edges", irq_modem, 1'b0);
        step();
        chk("R1 set on 3rd edge", irq_modem, 1'b1);
        for (int i = 0; i < 5; i++) step();
        chk("R2 holds without clear", irq_modem, 1'b1);
        modem_clr = 1; step(); modem_clr = 0;
        chk("R2 cleared", irq_modem, 1'b0);
        // clear coinciding with a new detected change
        modem_in[0] = 1;
        step(); step();
        modem_clr = 1; step();
        chk("R2 coincident clear keeps set", irq_modem, 1'b1);
        step(); modem_clr = 0;
        chk("R2 later clear works", irq_modem, 1'b0);

        // R4 / R5
        uart_en = 0; rx_line = 0;
        step();
        chk("R4 one edge not enough", irq_disabled, 1'b0);
        step();
        chk("R4 start bit while off", irq_disabled, 1'b1);
        uart_en = 1; #1;
        chk("R5 enable clears at once", irq_disabled, 1'b0);
        uart_en = 0; #1;
        chk("R4 re-disabled", irq_disabled, 1'b1);
        rx_line = 1;
        step();
        chk("R5 still set one edge after high", irq_disabled, 1'b1);
        step();
        chk("R5 cleared by line high", irq_disabled, 1'b0);
        uart_en = 1;

        // R6 / R7
        fifo_mode = 1; rx_level = 7;
        step();
        chk("R6 below half", irq_rx, 1'b0);
        rx_level = 8; #1;
        chk("R6 at half", irq_rx, 1'b1);
        fifo_mode = 0; #1;
        chk("R7 threshold ignored", irq_rx, 1'b0);
        rx_level = 16; #1;
        chk("R7 full level ignored", irq_rx, 1'b0);
        step();

        // R8 / R9
        rx_level = 3; rx_push = 1; step(); rx_push = 0;
        bit_tick = 1;
        for (int i = 0; i < LIMIT; i++) step();
        chk("R8 quiet after 32 ticks", irq_rx, 1'b0);
        step();
        chk("R8 fires on 33rd tick", irq_rx, 1'b1);
        for (int i = 0; i < 10; i++) step();
        chk("R9 timeout holds", irq_rx, 1'b1);
        rx_pop = 1; step(); rx_pop = 0;
        chk("R9 pop restarts", irq_rx, 1'b0);
        for (int i = 0; i < LIMIT + 1; i++) step();
        chk("R9 fires again", irq_rx, 1'b1);
        rx_level = 0; step();
        chk("R9 empty clears", irq_rx, 1'b0);
        bit_tick = 0;

        // R10
        modem_in[2] = 1;
        step(); step(); step();
        irq_en = 3'b000; #1;
        chk("R10 all masked", irq_any, 1'b0);
        irq_en = 3'b001; #1;
        chk("R10 modem enabled", irq_any, 1'b1);
        irq_en = 3'b110; #1;
        chk("R10 other enables only", irq_any, 1'b0);
        irq_en = 3'b111;
        modem_clr = 1; step(); modem_clr = 0;

        // constrained random
        for (int i = 0; i < 6000; i++) begin
            step();
            if ($urandom_range(39) == 0) modem_in[$urandom_range(2)] ^= 1'b1;
            if ($urandom_range(49) == 0) uart_en = ~uart_en;
            if ($urandom_range(7) == 0)  rx_line = ~rx_line;
            if ($urandom_range(199) == 0) fifo_mode = ~fifo_mode;
            if ($urandom_range(3) == 0) begin
                if ($urandom_range(1) == 0 && rx_level < DEPTH) rx_level++;
                else if (rx_level > 0) rx_level--;
            end
            rx_push   = ($urandom_range(299) == 0);
            rx_pop    = ($urandom_range(299) == 0);
            bit_tick  = ($urandom_range(2) == 0);
            modem_clr = ($urandom_range(9) == 0);
            if ($urandom_range(99) == 0) irq_en = 3'($urandom_range(7));
        end
        finish_run();
    end
endmodule